// File: doc/BRIEF.md
# DSP Peripheral Interrupt and DMA Window Registers

This block is the memory-mapped peripheral register file that sits beside a 24-bit DSP core. It keeps the interrupt status word, which records frame-start and frame-abort events, and it decodes a four-register window that belongs to the DMA engine. The core reaches it through an address, separate read and write strobes and 24-bit data. Reads and writes that land in the DMA window are passed through to the engine with a register select. Reads of the status word merge in the engine's end-of-list flag.

Status bits are cleared by writing ones to them. The end-of-list indication is never stored here: it is read live from the DMA engine. A write that sets bit 7 sends a one-cycle clear pulse back to the engine. A read of any address that is not mapped returns a fixed filler pattern. Read data is combinational and is valid in the same cycle as the read strobe.

Top module: `dsp_periph_regs`

## Requirements
- R1: A synchronous active-high reset clears both stored status bits, so a status read after reset returns 0 when the end-of-list input is low.
- R2: A cycle with `frame_start_evt` high sets status bit 1 from the next cycle on.
- R3: A cycle with `frame_abort_evt` high sets status bit 0 from the next cycle on.
- R4: A write to address 0xFFFFC5 clears each stored status bit whose position is 1 in the write data. Stored bits written with 0 keep their value.
- R5: If a set event and a clearing write to the same status bit fall in one cycle, the event wins and the bit is 1 afterwards.
- R6: A read of 0xFFFFC5 returns bit 0 = abort, bit 1 = start, bit 7 = `dma_eol`, and zeros elsewhere. Bit 7 follows the input in the same cycle and is not stored.
- R7: `dma_eol_clr` is high exactly in a cycle with a write to 0xFFFFC5 whose data bit 7 is 1.
- R8: Addresses 0xFFFFD4..0xFFFFD7 form the DMA window, with `dma_sel` = address bits [1:0] (0 next-block, 1 start-block, 2 control, 3 configuration). A write there raises `dma_wr` and passes `wdata` on `dma_wdata`. A read there raises `dma_rd` and returns `dma_rdata`. Outside the window `dma_wr`, `dma_rd` and `dma_sel` are 0.
- R9: A read of any other address returns 0x0ABABA.
- R10: A write to an unmapped address changes no status bit and raises no DMA strobe or clear pulse.
- R11: `rdata` is 0 in any cycle with `rd_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Peripheral address from the core |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data, valid in the cycle of `rd_en` |
| frame_start_evt | input | 1 | Frame-start event, one cycle per event |
| frame_abort_evt | input | 1 | Frame-abort event, one cycle per event |
| dma_eol | input | 1 | End-of-list flag held by the DMA engine |
| dma_eol_clr | output | 1 | Clear pulse for the DMA end-of-list flag |
| dma_sel | output | 2 | DMA register select |
| dma_wr | output | 1 | Write strobe to the DMA engine |
| dma_rd | output | 1 | Read strobe to the DMA engine |
| dma_wdata | output | 24 | Write data to the DMA engine |
| dma_rdata | input | 24 | Read data from the DMA engine |

## Verification
Two functions can collide in one cycle. The first is a hardware event setting a status bit. The second is a software write clearing the same bit. The bench provokes this by asserting `frame_start_evt` or `frame_abort_evt` in the same cycle as a write of ones to 0xFFFFC5. It judges the outcome by reading the status word in the following cycle, where the bit must still be 1. A second overlap places a status write with bit 7 set while `dma_eol` is high and a read is in flight. Here the clear pulse must appear and the read must still show bit 7 from the live input. A behavioural model in the bench tracks both bits and is compared with the outputs on every clock, including under randomised traffic.

// File: rtl/dsp_periph_pkg.sv
package dsp_periph_pkg;

    localparam int DW = 24;
    localparam int AW = 24;

    localparam logic [AW-1:0] STATUS_ADDR   = 24'hFFFFC5;
    localparam logic [AW-1:0] DMA_BASE_ADDR = 24'hFFFFD4;
    localparam logic [DW-1:0] FILLER_WORD   = 24'h0ABABA;

    localparam int BIT_ABORT = 0;
    localparam int BIT_START = 1;
    localparam int BIT_EOL   = 7;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_STATUS = 2'd1,
        RGN_DMA    = 2'd2
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [1:0] dma_sel;
    } decode_t;

    typedef struct packed {
        logic frame_start;
        logic frame_abort;
    } irq_stat_t;

    function automatic decode_t decode_addr(input logic [AW-1:0] a);
        decode_t d;
        d.region  = RGN_NONE;
        d.dma_sel = 2'd0;
        if (a == STATUS_ADDR) begin
            d.region = RGN_STATUS;
        end else if (a[AW-1:2] == DMA_BASE_ADDR[AW-1:2]) begin
            d.region  = RGN_DMA;
            d.dma_sel = a[1:0];
        end
        return d;
    endfunction

    function automatic logic [DW-1:0] status_word(input irq_stat_t s, input logic eol);
        logic [DW-1:0] w;
        w            = '0;
        w[BIT_ABORT] = s.frame_abort;
        w[BIT_START] = s.frame_start;
        w[BIT_EOL]   = eol;
        return w;
    endfunction

endpackage

// File: rtl/periph_addr_decode.sv
module periph_addr_decode
    import dsp_periph_pkg::*;
(
    input  logic [AW-1:0] addr,
    output decode_t       dec
);
    always_comb begin
        dec = decode_addr(addr);
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import dsp_periph_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_wr,
    input  logic [DW-1:0] clr_mask,
    input  logic          start_evt,
    input  logic          abort_evt,
    output irq_stat_t     stat_q
);
    irq_stat_t stat_d;

    always_comb begin
        stat_d = stat_q;
        if (clr_wr) begin
            stat_d.frame_start = stat_q.frame_start & ~clr_mask[BIT_START];
            stat_d.frame_abort = stat_q.frame_abort & ~clr_mask[BIT_ABORT];
        end
        if (start_evt) stat_d.frame_start = 1'b1;
        if (abort_evt) stat_d.frame_abort = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/periph_read_mux.sv
module periph_read_mux
    import dsp_periph_pkg::*;
(
    input  logic          rd_en,
    input  decode_t       dec,
    input  irq_stat_t     stat,
    input  logic          eol,
    input  logic [DW-1:0] dma_rdata,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (dec.region)
                RGN_STATUS: rdata = status_word(stat, eol);
                RGN_DMA:    rdata = dma_rdata;
                default:    rdata = FILLER_WORD;
            endcase
        end
    end
endmodule

// File: rtl/dsp_periph_regs.sv
module dsp_periph_regs
    import dsp_periph_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          frame_start_evt,
    input  logic          frame_abort_evt,
    input  logic          dma_eol,
    output logic          dma_eol_clr,
    output logic [1:0]    dma_sel,
    output logic          dma_wr,
    output logic          dma_rd,
    output logic [DW-1:0] dma_wdata,
    input  logic [DW-1:0] dma_rdata
);
    decode_t   dec;
    irq_stat_t stat_q;
    logic      status_wr;
    logic      in_window;

    periph_addr_decode u_dec (
        .addr (addr),
        .dec  (dec)
    );

    assign status_wr = wr_en && (dec.region == RGN_STATUS);
    assign in_window = (dec.region == RGN_DMA);

    irq_status_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .clr_wr    (status_wr),
        .clr_mask  (wdata),
        .start_evt (frame_start_evt),
        .abort_evt (frame_abort_evt),
        .stat_q    (stat_q)
    );

    periph_read_mux u_rmux (
        .rd_en     (rd_en),
        .dec       (dec),
        .stat      (stat_q),
        .eol       (dma_eol),
        .dma_rdata (dma_rdata),
        .rdata     (rdata)
    );

    assign dma_eol_clr = status_wr && wdata[BIT_EOL];
    assign dma_sel     = in_window ? dec.dma_sel : 2'd0;
    assign dma_wr      = wr_en && in_window;
    assign dma_rd      = rd_en && in_window;
    assign dma_wdata   = wdata;
endmodule

// File: rtl/dsp_periph_regs_chk.sv
module dsp_periph_regs_chk
    import dsp_periph_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic          frame_start_evt,
    input logic          frame_abort_evt,
    input logic          dma_eol_clr,
    input logic          dma_wr,
    input logic          dma_rd,
    input irq_stat_t     stat_q
);
    logic unmapped;
    assign unmapped = (addr != STATUS_ADDR) && (addr[AW-1:2] != DMA_BASE_ADDR[AW-1:2]);

    // R2
    start_sets_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start_evt |=> stat_q.frame_start);

    // R4
    w1c_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == STATUS_ADDR && wdata[BIT_ABORT] && !frame_abort_evt) |=> !stat_q.frame_abort);

    // R7
    eol_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
        dma_eol_clr |-> (wr_en && addr == STATUS_ADDR && wdata[BIT_EOL]));

    // R8
    dma_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_wr || dma_rd) |-> (addr[AW-1:2] == DMA_BASE_ADDR[AW-1:2]));

    // R9
    filler_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && unmapped) |-> (rdata == FILLER_WORD));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && unmapped && !frame_start_evt && !frame_abort_evt) |=> $stable(stat_q));

    // R11
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));
endmodule

bind dsp_periph_regs dsp_periph_regs_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .addr            (addr),
    .wr_en           (wr_en),
    .rd_en           (rd_en),
    .wdata           (wdata),
    .rdata           (rdata),
    .frame_start_evt (frame_start_evt),
    .frame_abort_evt (frame_abort_evt),
    .dma_eol_clr     (dma_eol_clr),
    .dma_wr          (dma_wr),
    .dma_rd          (dma_rd),
    .stat_q          (stat_q)
);

// File: tb/dsp_periph_regs_test.sv
module dsp_periph_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [23:0] wdata = '0;
    logic [23:0] rdata;
    logic        frame_start_evt = 1'b0;
    logic        frame_abort_evt = 1'b0;
    logic        dma_eol = 1'b0;
    logic        dma_eol_clr;
    logic [1:0]  dma_sel;
    logic        dma_wr;
    logic        dma_rd;
    logic [23:0] dma_wdata;
    logic [23:0] dma_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit m_start = 0;
    bit m_abort = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dsp_periph_regs uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .frame_start_evt(frame_start_evt),
        .frame_abort_evt(frame_abort_evt), .dma_eol(dma_eol),
        .dma_eol_clr(dma_eol_clr), .dma_sel(dma_sel), .dma_wr(dma_wr),
        .dma_rd(dma_rd), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata)
    );

    task automatic cmp(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%06h expected=%06h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        bit st  = (addr == 24'hFFFFC5);
        bit win = (addr >= 24'hFFFFD4) && (addr <= 24'hFFFFD7);
        logic [23:0] exp_rd;
        exp_rd = 24'h0;
        if (rd_en) begin
            if (st)       exp_rd = {16'h0, dma_eol, 5'b0, m_start, m_abort};
            else if (win) exp_rd = dma_rdata;
            else          exp_rd = 24'h0ABABA;
        end
        cmp(tag, "rdata", rdata, exp_rd);
        cmp(tag, "dma_wr", {23'h0, dma_wr}, {23'h0, wr_en && win});
        cmp(tag, "dma_rd", {23'h0, dma_rd}, {23'h0, rd_en && win});
        cmp(tag, "dma_sel", {22'h0, dma_sel}, win ? {22'h0, addr[1:0]} : 24'h0);
        cmp(tag, "dma_eol_clr", {23'h0, dma_eol_clr}, {23'h0, wr_en && st && wdata[7]});
        if (wr_en && win) cmp(tag, "dma_wdata", dma_wdata, wdata);
    endtask

    task automatic step(input string tag, input logic [23:0] a, input logic w, input logic r,
                        input logic [23:0] d, input logic se, input logic ae, input logic eo);
        @(negedge clk);
        addr = a; wr_en = w; rd_en = r; wdata = d;
        frame_start_evt = se; frame_abort_evt = ae; dma_eol = eo;
        dma_rdata = 24'h5A0000 | {16'h0, a[7:0]};
        #2;
        if (!rst) check_outputs(tag);
        @(posedge clk);
        if (rst) begin
            m_start = 0; m_abort = 0;
        end else begin
            if (w && a == 24'hFFFFC5) begin
                if (d[1]) m_start = 0;
                if (d[0]) m_abort = 0;
            end
            if (se) m_start = 1;
            if (ae) m_abort = 1;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    localparam logic [23:0] ST = 24'hFFFFC5;

    initial begin
        rst = 1'b1;
        step("R1", ST, 0, 0, 0, 1, 1, 0);
        step("R1", ST, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        // R1: status reads zero after reset
        step("R1", ST, 0, 1, 0, 0, 0, 0);
        // R2 / R3: events set bits
        step("R2", ST, 0, 0, 0, 1, 0, 0);
        step("R2", ST, 0, 1, 0, 0, 0, 0);
        step("R3", ST, 0, 0, 0, 0, 1, 0);
        step("R3", ST, 0, 1, 0, 0, 0, 0);
        // R4: clear only bit 1
        step("R4", ST, 1, 0, 24'h000002, 0, 0, 0);
        step("R4", ST, 0, 1, 0, 0, 0, 0);
        step("R4", ST, 1, 0, 24'hFFFFFF, 0, 0, 0);
        step("R4", ST, 0, 1, 0, 0, 0, 0);
        // R5: event beats clear in the same cycle
        step("R5", ST, 0, 0, 0, 1, 1, 0);
        step("R5", ST, 1, 1, 24'h000003, 1, 1, 0);
        step("R5", ST, 0, 1, 0, 0, 0, 0);
        // R6: eol merged live, not stored
        step("R6", ST, 0, 1, 0, 0, 0, 1);
        step("R6", ST, 0, 1, 0, 0, 0, 0);
        // R7: clear pulse only with bit 7
        step("R7", ST, 1, 1, 24'h000080, 0, 0, 1);
        step("R7", ST, 1, 0, 24'h00007F, 0, 0, 1);
        step("R7", 24'hFFFFD6, 1, 0, 24'h000080, 0, 0, 1);
        step("R7", ST, 0, 1, 0, 0, 0, 0);
        // R8: DMA window
        for (int i = 0; i < 4; i++) begin
            step("R8", 24'hFFFFD4 + i[23:0], 1, 0, 24'h123400 + i[23:0], 0, 0, 0);
            step("R8", 24'hFFFFD4 + i[23:0], 0, 1, 0, 0, 0, 0);
        end
        // R9: unmapped reads
        step("R9", 24'hFFFFD3, 0, 1, 0, 0, 0, 0);
        step("R9", 24'hFFFFD8, 0, 1, 0, 0, 0, 0);
        step("R9", 24'h000000, 0, 1, 0, 0, 0, 1);
        // R10: unmapped write ignored
        step("R10", ST, 0, 0, 0, 1, 1, 0);
        step("R10", 24'hFFFFC4, 1, 0, 24'hFFFFFF, 0, 0, 0);
        step("R10", 24'hFFFFC6, 1, 0, 24'hFFFFFF, 0, 0, 0);
        step("R10", ST, 0, 1, 0, 0, 0, 0);
        // R11: idle read bus
        step("R11", ST, 0, 0, 0, 0, 0, 1);
        step("R11", 24'hFFFFD5, 1, 0, 24'h00AAAA, 0, 0, 0);
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [23:0] a;
            int pick = $urandom_range(0, 3);
            case (pick)
                0: a = ST;
                1: a = 24'hFFFFD4 + 24'($urandom_range(0, 3));
                2: a = 24'hFFFFC0 + 24'($urandom_range(0, 31));
                default: a = 24'($urandom);
            endcase
            step("R5", a, 1'($urandom), 1'($urandom), 24'($urandom),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), 1'($urandom));
        end
        done = 1;
        finish_run();
    end
endmodule